// File: doc/BRIEF.md
# Clock Divider Sync Controller

This block divides a fast clock by a programmable integer from 1 to 8. An external, asynchronous sync pin can pull the divider back into a known phase. A small control word decides when sync edges reach the divider and how they act there. Continuous mode realigns the divider on every rising sync edge. One-shot mode realigns it once after software arms it and ignores every later edge until software arms it again.

Two enable bits gate the sync path and both must be set: an overall enable and a separate gate for the divider. The sync pin passes through a two-flop synchroniser, and the rising edge is taken from the synchronised samples. When a realignment happens, the divider counter restarts at zero, so a new output period begins on the following cycle. The outputs are a divided clock level, a one-cycle enable at the end of each period, and a flag that reports when the one-shot sync has fired.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, `sync_done` is 0 and the divider counter is at 0, so `div_clk` is 1.
- R2: The control word uses three bits. Bit 0 is the overall sync enable, bit 1 is the divider sync gate and bit 2 is the mode (0 = continuous, 1 = one-shot). A write stores bits 2:0. Bits 7:3 are ignored on write and read back as 0. Readback shows the stored value in the cycle after the write.
- R3: Suppose `sync_in` is first sampled high at clock edge k, and a realignment is allowed. Then the divider counter is 0 in the cycle that starts at edge k+2, and it counts up from there.
- R4: In continuous mode (bits 2:0 = 011), every rising edge of `sync_in` realigns the divider, and `sync_done` stays 0.
- R5: In one-shot mode, only the first rising sync edge after arming realigns the divider. That edge sets `sync_done` to 1, and later edges have no effect.
- R6: Writing 111 to bits 2:0 arms the one-shot. Any write clears `sync_done`, and a write of any other value disarms the one-shot.
- R7: While bit 0 is 0, no sync edge changes the divider phase, whatever the other bits hold.
- R8: While bit 1 is 0, no sync edge changes the divider phase, even when bit 0 is 1.
- R9: The period is `div_ratio`+1 cycles. The counter runs from 0 to `div_ratio` and then wraps to 0. If the ratio shrinks below the current count, the counter wraps on the next edge.
- R10: `div_clk` is 1 for the first ceil(N/2) cycles of each N-cycle period. `div_en` is 1 in the last cycle of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous sync pin |
| div_ratio | input | 3 | Divide ratio minus one (0 to 7) |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word readback |
| div_clk | output | 1 | Divided clock level |
| div_en | output | 1 | One-cycle pulse in the last cycle of each period |
| sync_done | output | 1 | One-shot sync has fired since the last write |

## Verification
A fixed-latency case places a sync edge where the realigned and the free-running counters give different `div_clk` levels. This confirms the two-stage synchroniser delay and the restart at zero. Repeated sync pulses are applied in continuous mode, in one-shot mode, in one-shot mode after re-arming, and with each enable cleared. These runs separate "every edge", "first edge only" and "no edge" behaviour. Divide ratios of 1, 3, 5 and 8 are used together with sync pulses, and the ratio is lowered below the running count to exercise the wrap rule. A write of 0xF8 shows that the reserved bits are dropped.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

  localparam int CTRL_W     = 8;
  localparam int BIT_MASTER = 0;
  localparam int BIT_GATE   = 1;
  localparam int BIT_MODE   = 2;
  localparam int CFG_W      = 3;

  typedef struct packed {
    logic one_shot;
    logic div_gate;
    logic master;
  } sync_cfg_t;

  function automatic sync_cfg_t cfg_from_word(input logic [CTRL_W-1:0] w);
    sync_cfg_t c;
    c.master   = w[BIT_MASTER];
    c.div_gate = w[BIT_GATE];
    c.one_shot = w[BIT_MODE];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] cfg_to_word(input sync_cfg_t c);
    logic [CTRL_W-1:0] w;
    w             = '0;
    w[BIT_MASTER] = c.master;
    w[BIT_GATE]   = c.div_gate;
    w[BIT_MODE]   = c.one_shot;
    return w;
  endfunction

  function automatic logic cfg_arms(input sync_cfg_t c);
    return c.master & c.div_gate & c.one_shot;
  endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] meta_q;
  logic         prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= {meta_q[TOP-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= meta_q[TOP];
  end

  assign rise = meta_q[TOP] & ~prev_q;
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg
  import clkdiv_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              sync_rise,
  output logic [CTRL_W-1:0] rdata,
  output logic              armed,
  output logic              done,
  output logic              fire
);
  sync_cfg_t cfg_q;
  sync_cfg_t cfg_new;
  logic      armed_q;
  logic      done_q;
  logic      path_open;
  logic      unused_reserved;

  assign cfg_new         = cfg_from_word(wdata);
  assign unused_reserved = ^wdata[CTRL_W-1:CFG_W];

  assign path_open = cfg_q.master & cfg_q.div_gate;
  assign fire      = sync_rise & path_open & (~cfg_q.one_shot | armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (we) begin
      cfg_q   <= cfg_new;
      armed_q <= cfg_arms(cfg_new);
      done_q  <= 1'b0;
    end else if (fire && cfg_q.one_shot) begin
      armed_q <= 1'b0;
      done_q  <= 1'b1;
    end
  end

  assign rdata = cfg_to_word(cfg_q);
  assign armed = armed_q;
  assign done  = done_q;
endmodule

// File: rtl/phase_divider.sv
module phase_divider #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               realign,
  input  logic [RATIO_W-1:0] last,
  output logic [RATIO_W-1:0] count,
  output logic               div_clk,
  output logic               div_en
);
  localparam int EXT_W = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q;

  function automatic logic [RATIO_W-1:0] next_count(
    input logic [RATIO_W-1:0] c,
    input logic [RATIO_W-1:0] l,
    input logic               r
  );
    if (r || c >= l) return '0;
    return c + 1'b1;
  endfunction

  function automatic logic in_high_phase(
    input logic [RATIO_W-1:0] c,
    input logic [RATIO_W-1:0] l
  );
    logic [EXT_W-1:0] half;
    half = ({1'b0, l} + EXT_W'(2)) >> 1;
    return {1'b0, c} < half;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, last, realign);
  end

  assign count   = cnt_q;
  assign div_clk = in_high_phase(cnt_q, last);
  assign div_en  = (cnt_q == last);
endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
  import clkdiv_sync_pkg::*;
#(
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  output logic [CTRL_W-1:0]  ctrl_rdata,
  output logic               div_clk,
  output logic               div_en,
  output logic               sync_done
);
  logic               sync_rise;
  logic               sync_fire;
  logic               sync_armed;
  logic [RATIO_W-1:0] cnt_q;

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sync_in),
    .rise     (sync_rise)
  );

  sync_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctrl_we),
    .wdata     (ctrl_wdata),
    .sync_rise (sync_rise),
    .rdata     (ctrl_rdata),
    .armed     (sync_armed),
    .done      (sync_done),
    .fire      (sync_fire)
  );

  phase_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (sync_fire),
    .last    (div_ratio),
    .count   (cnt_q),
    .div_clk (div_clk),
    .div_en  (div_en)
  );
endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk
  import clkdiv_sync_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_we,
  input logic [CTRL_W-1:0]  ctrl_wdata,
  input logic [CTRL_W-1:0]  ctrl_rdata,
  input logic               sync_done,
  input logic               sync_fire,
  input logic               sync_armed,
  input logic               div_en,
  input logic [RATIO_W-1:0] div_ratio,
  input logic [RATIO_W-1:0] cnt_q
);
  // Reset values of the control word and flag (R1)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (ctrl_rdata == '0 && !sync_done);
    end
  end

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_rdata == {{(CTRL_W-CFG_W){1'b0}}, $past(ctrl_wdata[CFG_W-1:0])});

  assert_realign_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |=> cnt_q == '0);

  assert_continuous_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[BIT_MODE] && !ctrl_we) |=> !sync_done);

  assert_oneshot_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done && ctrl_rdata[BIT_MODE]) |-> !sync_fire);

  assert_oneshot_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fire && ctrl_rdata[BIT_MODE] && !ctrl_we) |=> sync_done && !sync_armed);

  assert_write_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !sync_done);

  assert_master_off_free_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[BIT_MASTER] && cnt_q < div_ratio) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_gate_off_free_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[BIT_GATE] && cnt_q < div_ratio) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_period_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |=> cnt_q == '0);
endmodule

bind clkdiv_sync_ctrl clkdiv_sync_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_rdata (ctrl_rdata),
  .sync_done  (sync_done),
  .sync_fire  (sync_fire),
  .sync_armed (sync_armed),
  .div_en     (div_en),
  .div_ratio  (div_ratio),
  .cnt_q      (cnt_q)
);

// File: tb/clkdiv_sync_ctrl_bench.sv
module clkdiv_sync_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic [2:0] div_ratio = 3'd7;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       div_clk, div_en, sync_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_p1 = 0, m_p2 = 0, m_p3 = 0;
  int m_cnt = 0, m_ctrl = 0, m_arm = 0, m_done = 0;

  always #10 clk = ~clk;

  clkdiv_sync_ctrl u_clkdiv_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .div_ratio(div_ratio),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .div_clk(div_clk), .div_en(div_en), .sync_done(sync_done)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: advance one clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_cnt = 0; m_ctrl = 0; m_arm = 0; m_done = 0;
    end else begin
      int lim;
      bit rose, go;
      lim  = div_ratio;
      rose = (m_p2 == 1) && (m_p3 == 0);
      go   = rose && (m_ctrl % 2 == 1) && ((m_ctrl / 2) % 2 == 1) &&
             (m_ctrl < 4 || m_arm == 1);
      if (go || m_cnt >= lim) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (ctrl_we) begin
        m_ctrl = ctrl_wdata % 8;
        m_arm  = (m_ctrl == 7) ? 1 : 0;
        m_done = 0;
      end else if (go && m_ctrl >= 4) begin
        m_arm = 0; m_done = 1;
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = sync_in;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      int n;
      n = div_ratio + 1;
      chk(cur_req, div_clk, (m_cnt < (n + 1) / 2) ? 1 : 0, "div_clk");
      chk(cur_req, div_en, (m_cnt == div_ratio) ? 1 : 0, "div_en");
      chk(cur_req, ctrl_rdata, m_ctrl, "ctrl_rdata");
      chk(cur_req, sync_done, m_done, "sync_done");
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic pulse(input int hi, input int gap);
    @(negedge clk); sync_in = 1'b1;
    repeat (hi) @(negedge clk);
    sync_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic count_en(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #5;
      if (div_en) seen++;
    end
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", ctrl_rdata, 0, "reset ctrl");
    chk("R1", sync_done, 0, "reset done");

    // R2 reserved bits and readback
    cur_req = "R2";
    wr(8'hF8);
    chk("R2", ctrl_rdata, 0, "reserved write");
    wr(8'h03);
    chk("R2", ctrl_rdata, 3, "continuous write");

    // R3 latency: sync sampled at edge k restarts counter at k+2
    cur_req = "R3";
    do begin @(posedge clk); #5; end while (!div_en);
    @(posedge clk); @(posedge clk);
    @(negedge clk); sync_in = 1'b1;
    repeat (5) @(posedge clk);
    #5 chk("R3", div_clk, 1, "realigned high phase 1");
    @(posedge clk); #5 chk("R3", div_clk, 1, "realigned high phase 2");
    @(posedge clk); #5 chk("R3", div_clk, 0, "realigned low phase");
    @(negedge clk); sync_in = 1'b0;
    repeat (4) @(negedge clk);

    // R4 continuous mode: every edge
    cur_req = "R4";
    pulse(3, 10); pulse(2, 13); pulse(4, 9);
    chk("R4", sync_done, 0, "no done in continuous");

    // R9 / R10 ratios with sync activity
    cur_req = "R9";
    div_ratio = 3'd0; pulse(2, 6);
    div_ratio = 3'd2; pulse(2, 9);
    cur_req = "R10";
    div_ratio = 3'd4; pulse(3, 12);
    div_ratio = 3'd7; repeat (6) @(negedge clk);
    cur_req = "R9";
    div_ratio = 3'd1; repeat (4) @(negedge clk);
    div_ratio = 3'd7;

    // R5 one-shot
    cur_req = "R5";
    wr(8'h07);
    chk("R5", sync_done, 0, "armed not done");
    pulse(3, 8);
    chk("R5", sync_done, 1, "done after first edge");
    pulse(2, 11); pulse(3, 7);
    chk("R5", sync_done, 1, "done held");

    // R6 re-arm and disarm
    cur_req = "R6";
    wr(8'h07);
    chk("R6", sync_done, 0, "re-arm clears done");
    pulse(2, 9);
    chk("R6", sync_done, 1, "re-armed fires");
    wr(8'h03);
    chk("R6", sync_done, 0, "write clears done");
    wr(8'h04);
    pulse(2, 9);
    chk("R6", sync_done, 0, "disarmed no fire");

    // R7 master off: regular period despite sync
    cur_req = "R7";
    wr(8'h06);
    fork
      begin pulse(2, 9); pulse(3, 11); pulse(2, 8); end
      count_en(40, seen);
    join
    chk("R7", seen, 5, "div_en count, master off");
    chk("R7", sync_done, 0, "no done, master off");

    // R8 gate off
    cur_req = "R8";
    wr(8'h05);
    fork
      begin pulse(3, 10); pulse(2, 12); pulse(2, 7); end
      count_en(40, seen);
    join
    chk("R8", seen, 5, "div_en count, gate off");
    chk("R8", sync_done, 0, "no done, gate off");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule